// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block collects up to 27 event sources into one sticky status word and drives a single combined interrupt line. A hardware source sets its status bit with a one-cycle pulse. The bit then stays set until software writes a one to that bit position. A mask word chooses which status bits may reach the output. One global enable bit gates the combined line as a whole. The block also reports the lowest-numbered source that is both set and unmasked, and it raises a flag when no such source exists. The interrupt service routine uses that flag to recognise a spurious entry.

The source map follows the usual arrangement for a bus host. Bits 0 to 3 carry inbound descriptor events: done, success, failure and list exhausted. Bits 4 to 7 carry the same four events for the outbound direction. Bit 9 reports that the inbound direction ran out of descriptors. Bit 26 reports an aborted bus transaction. Bit 25 does not come from a pulse. It is the level of an external device's interrupt wire, which the block samples itself. A typical bring-up sequence is:

1. Turn the global enable off.
2. Mask the abort and external sources.
3. Clear their status bits.
4. Turn the global enable on.

The block offers a fourth register offset that masks and acknowledges chosen sources in a single write.

Top module: `irq_gather`

## Requirements
- R1: After reset, the status, mask and enable registers read as zero, `irq_out` is 0, `none_pend` is 1 and `pend_idx` is 0.
- R2: A pulse on `evt_pulse[i]` (for i not equal to 25) sets status bit i at the next clock edge. The bit stays set until software clears it.
- R3: A write to offset 0 clears every status bit whose data bit is 1 and leaves every status bit whose data bit is 0 unchanged.
- R4: When a set pulse and a software clear reach the same status bit in the same cycle, the bit ends up set.
- R5: The pending set is status AND mask. `irq_out` is 1 exactly when the enable bit is 1 and the pending set is non-zero.
- R6: When enable bit 0 (written at offset 2) is 0, `irq_out` is 0 whatever the status and mask hold.
- R7: `pend_idx` gives the lowest bit number in the pending set. `none_pend` is 1 and `pend_idx` is 0 when the pending set is empty.
- R8: Status bit 25 is set by the level of `ext_line` through a two-flop synchroniser. A rise of `ext_line` is visible in the status after the third clock edge and not after the second. `evt_pulse[25]` has no effect.
- R9: A write to offset 3 clears both the mask bits and the status bits where the data is 1, in the same cycle. Other bits keep their values.
- R10: Reads are combinational from `reg_addr`:
  - offset 0 returns the status.
  - offset 1 returns the mask.
  - offset 2 returns the enable bit in bit 0.
  - offset 3 returns `none_pend` in bit 31 and `pend_idx` in the low bits.
- R11: Data bits 27 to 31 of writes to offsets 0, 1 and 3 are ignored. Status and mask read back as zero in bits 27 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 27 | One-cycle set pulses, one per source (bit 25 unused) |
| ext_line | input | 1 | Asynchronous external interrupt level for source 25 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 status, 1 mask, 2 enable, 3 mask-and-acknowledge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt line |
| pend_idx | output | 5 | Lowest pending unmasked source |
| none_pend | output | 1 | Pending set is empty |

## Verification
Some properties are checked on every cycle:
- Status bits are never gained except from a set source in the previous cycle, and a set source always lands (R2, R4).
- Cleared bits drop unless they were set again in the same cycle (R3).
- The combined line is never high without the enable and a pending source (R5, R6).
- The reported index is a pending bit with no lower pending bit below it (R7).
- A mask-and-acknowledge write leaves the chosen mask bits clear (R9).

Other behaviour needs the bench's scenarios:
- The exact three-edge latency of the external line, and the proof that its pulse input is ignored (R8).
- Register readback encodings and the dropped upper data bits (R10, R11).
- Long random mixes of set pulses, clears and mask changes, checked against a reference model.

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int NSRC    = 27,
  parameter int DW      = 32,
  parameter int EXT_IDX = 25,
  localparam int IDX_W  = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  evt_pulse,
  input  logic             ext_line,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq_out,
  output logic [IDX_W-1:0] pend_idx,
  output logic             none_pend
);

  localparam logic [1:0] OFS_STAT = 2'd0;
  localparam logic [1:0] OFS_MASK = 2'd1;
  localparam logic [1:0] OFS_GEN  = 2'd2;
  localparam logic [1:0] OFS_ACK  = 2'd3;
  localparam logic [NSRC-1:0] EXT_BIT = NSRC'(1) << EXT_IDX;

  logic [NSRC-1:0] status, mask, pending, set_vec, clr_vec;
  logic            gen_en;
  logic            ext_s1, ext_s2;
  logic [NSRC-1:0] wbits;
  logic            unused_hi;

  assign wbits     = reg_wdata[NSRC-1:0];
  assign unused_hi = ^reg_wdata[DW-1:NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
    end else begin
      ext_s1 <= ext_line;
      ext_s2 <= ext_s1;
    end
  end

  assign set_vec = (evt_pulse & ~EXT_BIT) | (ext_s2 ? EXT_BIT : '0);
  assign clr_vec = (reg_wr && (reg_addr == OFS_STAT || reg_addr == OFS_ACK)) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask   <= '0;
      gen_en <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_MASK: mask   <= wbits;
        OFS_ACK:  mask   <= mask & ~wbits;
        OFS_GEN:  gen_en <= reg_wdata[0];
        default:  ;
      endcase
    end
  end

  assign pending   = status & mask;
  assign none_pend = ~|pending;
  assign irq_out   = gen_en & ~none_pend;

  always_comb begin
    pend_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pending[i]) pend_idx = IDX_W'(i);
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT: reg_rdata = DW'(status);
      OFS_MASK: reg_rdata = DW'(mask);
      OFS_GEN:  reg_rdata = DW'(gen_en);
      default:  reg_rdata = {none_pend, {(DW-1-IDX_W){1'b0}}, pend_idx};
    endcase
  end

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec)) == $past(set_vec))) // R4
    else $error("set source lost");

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0)) // R2
    else $error("status gained without source");

  AST_W1C_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_STAT) |=> ((status & $past(wbits) & ~$past(set_vec)) == '0)) // R3
    else $error("cleared bit stayed");

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (gen_en && (status & mask) != '0)) // R6
    else $error("irq without enable and pending");

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    !none_pend |-> (pending[pend_idx] && (pending & ((NSRC'(1) << pend_idx) - NSRC'(1))) == '0)) // R7
    else $error("index not lowest pending");

  AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_ACK) |=> ((mask & $past(wbits)) == '0)) // R9
    else $error("ack left mask bit");

endmodule

// File: tb/irq_gather_test.sv
module irq_gather_test;
  localparam int NSRC = 27;
  localparam int EXT  = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] evt_pulse = '0;
  logic ext_line = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_out, none_pend;
  logic [4:0] pend_idx;

  int n_cmp = 0, n_bad = 0;
  logic [NSRC-1:0] m_st = '0, m_mk = '0;
  logic m_en = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;

  always #4 clk = ~clk;

  irq_gather uut (.clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .ext_line(ext_line),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .pend_idx(pend_idx), .none_pend(none_pend));

  function automatic logic [4:0] f_idx(input logic [NSRC-1:0] p);
    logic [4:0] r = '0;
    for (int i = NSRC - 1; i >= 0; i--) if (p[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [31:0] f_rd(input logic [1:0] a);
    logic [NSRC-1:0] p = m_st & m_mk;
    case (a)
      2'd0: return 32'(m_st);
      2'd1: return 32'(m_mk);
      2'd2: return 32'(m_en);
      default: return {(p == '0), 26'd0, f_idx(p)};
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NSRC-1:0] e, input logic x, input logic w,
                      input logic [1:0] a, input logic [31:0] d);
    logic [NSRC-1:0] clr, setv, ns, nm, p;
    logic ne;
    @(negedge clk);
    evt_pulse = e; ext_line = x; reg_wr = w; reg_addr = a; reg_wdata = d;
    clr  = (w && (a == 2'd0 || a == 2'd3)) ? d[NSRC-1:0] : '0;
    setv = (e & ~(NSRC'(1) << EXT)) | (m_s2 ? (NSRC'(1) << EXT) : '0);
    ns = (m_st & ~clr) | setv;
    nm = (w && a == 2'd1) ? d[NSRC-1:0] : (w && a == 2'd3) ? (m_mk & ~d[NSRC-1:0]) : m_mk;
    ne = (w && a == 2'd2) ? d[0] : m_en;
    @(posedge clk); #1;
    m_st = ns; m_mk = nm; m_en = ne; m_s2 = m_s1; m_s1 = x;
    evt_pulse = '0; reg_wr = 1'b0;
    p = m_st & m_mk;
    check("R5 irq_out", 32'(irq_out), 32'(m_en && p != '0));
    check("R7 pend_idx", 32'(pend_idx), 32'(f_idx(p)));
    check("R7 none_pend", 32'(none_pend), 32'(p == '0));
    check("R10 rdata", reg_rdata, f_rd(a));
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq", 32'(irq_out), 0);
    check("R1 none", 32'(none_pend), 1);
    check("R1 idx", 32'(pend_idx), 0);
    @(negedge clk); rst_n = 1'b1;
    rd(2'd0, "R1 status", 0);
    rd(2'd1, "R1 mask", 0);
    rd(2'd2, "R1 enable", 0);

    step(27'h10, 0, 0, 2'd0, 0);
    step('0, 0, 0, 2'd0, 0);
    rd(2'd0, "R2 bit4 sticky", 32'h10);
    step('0, 0, 1, 2'd0, 32'h0);
    rd(2'd0, "R3 zero write keeps", 32'h10);
    step(27'h10, 0, 1, 2'd0, 32'h10);
    rd(2'd0, "R4 set beats clear", 32'h10);
    step('0, 0, 1, 2'd0, 32'h10);
    rd(2'd0, "R3 one write clears", 32'h0);

    step(27'h200 | 27'h400_0000, 0, 1, 2'd1, 32'hFFFF_FFFF);
    rd(2'd1, "R11 mask upper dropped", 32'h07FF_FFFF);
    check("R6 gated off", 32'(irq_out), 0);
    step('0, 0, 1, 2'd2, 32'h1);
    check("R6 enabled on", 32'(irq_out), 1);
    rd(2'd3, "R10 R7 idx 9", 32'd9);

    step('0, 0, 1, 2'd3, 32'h200);
    rd(2'd1, "R9 mask bit9 cleared", 32'h07FF_FDFF);
    rd(2'd0, "R9 status bit9 cleared", 32'h0400_0000);
    rd(2'd3, "R7 idx 26", 32'd26);
    step('0, 0, 1, 2'd0, 32'hFFFF_FFFF);
    rd(2'd3, "R7 none flag", 32'h8000_0000);
    check("R5 no irq when empty", 32'(irq_out), 0);

    step(27'(1) << EXT, 0, 0, 2'd0, 0);
    rd(2'd0, "R8 pulse ignored", 0);
    step('0, 1, 0, 2'd0, 0);
    step('0, 1, 0, 2'd0, 0);
    rd(2'd0, "R8 not after two edges", 0);
    step('0, 1, 0, 2'd0, 0);
    rd(2'd0, "R8 set after three edges", 32'h0200_0000);
    step('0, 0, 1, 2'd0, 32'h0200_0000);
    rd(2'd0, "R4 level holds bit", 32'h0200_0000);
    step('0, 0, 0, 2'd0, 0);
    step('0, 0, 0, 2'd0, 0);
    step('0, 0, 1, 2'd0, 32'h0200_0000);
    rd(2'd0, "R3 ext cleared after drop", 0);

    for (int k = 0; k < 4000; k++) begin
      logic [NSRC-1:0] e;
      logic [31:0] d;
      e = ($urandom % 4 == 0) ? NSRC'($urandom & $urandom) : '0;
      d = ($urandom % 2) ? $urandom : ($urandom & $urandom & $urandom);
      step(e, ($urandom % 16) < 3, ($urandom % 3) == 0, 2'($urandom), d);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule